// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control engine of one DMA channel. When software enables the channel, it captures a programmed source address, destination address, item count, a data width for each side, an increment enable for each side and a circular-mode bit. While the channel is active, each grant from an external arbiter moves one data item. The block issues one read on a request/acknowledge read port, converts the returned value to the destination width, and then issues one write on a matching write port. After each item it steps the addresses, counts down the remaining items, and records half-transfer, transfer-complete and transfer-error events.

The three events are sticky flags. Each flag has its own clear input and its own interrupt enable, and the enabled flags are ORed onto one interrupt line. In normal mode the channel goes inactive after the last item. In circular mode it reloads its count and both addresses and keeps running. Bus data is right-aligned: a byte or half-word item uses the low bits of the 32-bit data bus. Arbitration between channels and the bus fabric sit outside this block.

Top module: `dmach_seq`

## Requirements
- R1: A rising edge of `ch_en` while inactive, with valid widths and aligned addresses, makes `active` high at the next clock. `remain` is then loaded with `cfg_count`, where a count of 0 loads 65536.
- R2: For each item, the block waits in the active state until it samples `grant` high. It then holds `rd_req` with `rd_size` equal to the source width until `rd_ack`, then holds `wr_req` with `wr_size` equal to the destination width until `wr_ack`. `rd_req` and `wr_req` are never high together.
- R3: Width codes are 0 for a byte, 1 for a half-word and 2 for a word. After each completed item, an address whose increment enable is set advances by 1, 2 or 4 bytes according to its own side's width. An address whose increment enable is clear stays fixed.
- R4: `wr_data` is the captured read data with every bit above the narrower of the two widths forced to zero. A narrow read into a wide write is zero-extended, and a wide read into a narrow write keeps its low bits.
- R5: `remain` drops by one at each write acknowledged without error. In normal mode the item that takes it from 1 to 0 sets `flag_tc` and clears `active`.
- R6: In circular mode the last item sets `flag_tc`, reloads `remain` and both addresses from their programmed values, and leaves the channel active.
- R7: `flag_ht` sets when a completed item leaves `remain` equal to the programmed count divided by two, rounded down. With a count of 1, this falls on the same item as `flag_tc`.
- R8: An enable edge with a width code of 3, or with either address not aligned to its own width, sets `flag_te` and leaves the channel inactive.
- R9: A read or write acknowledged with its error input high sets `flag_te` and makes the channel inactive. No further request follows.
- R10: Each flag stays set until its own clear input is high at a clock edge. A clear input affects only its own flag.
- R11: `irq` is high exactly when a flag is set and its enable is set. Bit 0 of `cfg_ie` enables half-transfer, bit 1 enables complete, and bit 2 enables error.
- R12: `ch_en` low at a clock edge makes the channel inactive and withdraws any pending request. `remain` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ch_en | input | 1 | Channel enable; a rising edge starts, low stops |
| cfg_src_addr | input | ADDR_W | Programmed source address |
| cfg_dst_addr | input | ADDR_W | Programmed destination address |
| cfg_count | input | CNT_W | Item count, 0 meaning 2^CNT_W |
| cfg_src_w | input | 2 | Source width code |
| cfg_dst_w | input | 2 | Destination width code |
| cfg_src_inc | input | 1 | Source address increment enable |
| cfg_dst_inc | input | 1 | Destination address increment enable |
| cfg_circ | input | 1 | Circular mode |
| cfg_ie | input | 3 | Interrupt enables {error, complete, half} |
| grant | input | 1 | Arbiter grant for the next item |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_size | output | 2 | Read width code |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Read data, right-aligned |
| rd_err | input | 1 | Read error, qualified by rd_ack |
| wr_req | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_size | output | 2 | Write width code |
| wr_data | output | 32 | Write data, right-aligned |
| wr_ack | input | 1 | Write acknowledge |
| wr_err | input | 1 | Write error, qualified by wr_ack |
| clr_ht | input | 1 | Clear half-transfer flag |
| clr_tc | input | 1 | Clear complete flag |
| clr_te | input | 1 | Clear error flag |
| flag_ht | output | 1 | Half-transfer flag |
| flag_tc | output | 1 | Transfer-complete flag |
| flag_te | output | 1 | Transfer-error flag |
| irq | output | 1 | Merged, enabled interrupt |
| active | output | 1 | Channel running |
| remain | output | CNT_W+1 | Items still to move |

## Verification
The bench targets the following corner cases:
- **Odd counts and a count of one.** The half-transfer point must land on the rounded-down half. A design that rounded up, or compared before the decrement, would raise `flag_ht` one item early or late.
- **Mixed widths in both directions.** A design that masked with the wrong side's width would leak high bits into `wr_data`. One that stepped an address by the other side's width would drift off the expected addresses.
- **Circular runs across several wraps, and a count of 0.** A design that forgot to reload the addresses, or treated 0 as zero items, would stop or write to the wrong place.
- **Error paths.** These are a misaligned enable, an illegal width, and error acknowledges on each port. A design that kept requesting after an error, or that cleared the wrong flag, would show up at once in the request and flag outputs.

// File: rtl/dmach_pkg.sv
// Shared types and helpers for the DMA channel sequencer.
// Assumes data items are right-aligned on a 32-bit bus.
package dmach_pkg;

    localparam int DMACH_DW = 32;

    // Flag slot positions, shared by the flag bank and the top level.
    localparam int FL_HT = 0;
    localparam int FL_TC = 1;
    localparam int FL_TE = 2;
    localparam int FL_N  = 3;

    typedef enum logic [1:0] {
        XW_BYTE = 2'd0,
        XW_HALF = 2'd1,
        XW_WORD = 2'd2
    } xfer_w_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } seq_st_e;

    // Byte count of one item of the given width code.
    function automatic logic [2:0] xw_bytes(input logic [1:0] w);
        case (w)
            XW_BYTE: xw_bytes = 3'd1;
            XW_HALF: xw_bytes = 3'd2;
            default: xw_bytes = 3'd4;
        endcase
    endfunction

    // Mask keeping the bits of one item of the given width code.
    function automatic logic [DMACH_DW-1:0] xw_mask(input logic [1:0] w);
        case (w)
            XW_BYTE: xw_mask = {{(DMACH_DW-8){1'b0}}, 8'hFF};
            XW_HALF: xw_mask = {{(DMACH_DW-16){1'b0}}, 16'hFFFF};
            default: xw_mask = {DMACH_DW{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/dmach_cfg_chk.sv
// Configuration checker: flags an illegal width code or an address not
// aligned to its own side's width. Purely combinational.
// Assumes only the two low address bits matter for alignment.
module dmach_cfg_chk
    import dmach_pkg::*;
(
    input  logic [1:0] src_lo,
    input  logic [1:0] dst_lo,
    input  logic [1:0] src_w,
    input  logic [1:0] dst_w,
    output logic       cfg_ok
);

    logic [1:0] lo     [2];
    logic [1:0] wcode  [2];
    logic       side_ok[2];

    assign lo[0]    = src_lo;
    assign lo[1]    = dst_lo;
    assign wcode[0] = src_w;
    assign wcode[1] = dst_w;

    for (genvar g = 0; g < 2; g++) begin : g_side
        // Legal width and address aligned to it.
        always_comb begin
            case (wcode[g])
                XW_BYTE: side_ok[g] = 1'b1;
                XW_HALF: side_ok[g] = ~lo[g][0];
                XW_WORD: side_ok[g] = (lo[g] == 2'b00);
                default: side_ok[g] = 1'b0;
            endcase
        end
    end

    assign cfg_ok = side_ok[0] & side_ok[1];

endmodule

// File: rtl/dmach_addr_gen.sv
// Address generator for one side of the channel. Keeps the programmed
// start address and the current address; steps by the item size when
// incrementing, or rewinds to the start on a circular wrap.
// Assumes width is stable from load until the next load.
module dmach_addr_gen
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              adv,
    input  logic              inc,
    input  logic [1:0]        width,
    input  logic              rewind,
    output logic [ADDR_W-1:0] cur
);

    logic [ADDR_W-1:0] prog_q;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] step;

    assign step = {{(ADDR_W-3){1'b0}}, xw_bytes(width)};

    // Capture start address; step or rewind after each item.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_q <= '0;
            cur_q  <= '0;
        end else if (ld) begin
            prog_q <= ld_addr;
            cur_q  <= ld_addr;
        end else if (adv) begin
            if (rewind) begin
                cur_q <= prog_q;
            end else if (inc) begin
                cur_q <= cur_q + step;
            end
        end
    end

    assign cur = cur_q;

endmodule

// File: rtl/dmach_cnt.sv
// Remaining-item counter with half and complete detection.
// A loaded count of zero stands for 2^CNT_W items.
// Assumes step is only pulsed while remain is nonzero.
module dmach_cnt #(
    parameter int CNT_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld,
    input  logic [CNT_W-1:0] ld_cnt,
    input  logic           circ,
    input  logic           step,
    output logic [CNT_W:0] remain,
    output logic           last,
    output logic           ht_evt,
    output logic           tc_evt
);

    localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};
    localparam logic [CNT_W:0] ONE  = {{CNT_W{1'b0}}, 1'b1};

    logic [CNT_W:0] tot_q;
    logic [CNT_W:0] rem_q;
    logic [CNT_W:0] ld_tot;

    assign ld_tot = (ld_cnt == '0) ? FULL : {1'b0, ld_cnt};

    // Load the total, count down per item, reload on a circular wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tot_q <= '0;
            rem_q <= '0;
        end else if (ld) begin
            tot_q <= ld_tot;
            rem_q <= ld_tot;
        end else if (step) begin
            if (last) begin
                rem_q <= circ ? tot_q : '0;
            end else begin
                rem_q <= rem_q - ONE;
            end
        end
    end

    assign last   = (rem_q == ONE);
    assign ht_evt = step & ((rem_q - ONE) == (tot_q >> 1));
    assign tc_evt = step & last;
    assign remain = rem_q;

endmodule

// File: rtl/dmach_flags.sv
// Sticky event flags with per-flag clear and interrupt enable, merged
// into one interrupt line. A set in the same cycle as a clear wins.
module dmach_flags #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    input  logic [NF-1:0] ie,
    output logic [NF-1:0] flags,
    output logic          irq
);

    logic [NF-1:0] fl_q;

    for (genvar g = 0; g < NF; g++) begin : g_flag
        // Hold one event until its own clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fl_q[g] <= 1'b0;
            end else begin
                fl_q[g] <= set[g] | (fl_q[g] & ~clr[g]);
            end
        end
    end

    assign flags = fl_q;
    assign irq   = |(fl_q & ie);

endmodule

// File: rtl/dmach_seq.sv
// DMA channel transfer sequencer (top). On an enable edge it checks
// and captures the channel setup. Each grant then moves one item with
// a read followed by a write, converting between the two widths.
// Assumes ack/error inputs are only high while the matching request is.
module dmach_seq
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ch_en,
    input  logic [ADDR_W-1:0]   cfg_src_addr,
    input  logic [ADDR_W-1:0]   cfg_dst_addr,
    input  logic [CNT_W-1:0]    cfg_count,
    input  logic [1:0]          cfg_src_w,
    input  logic [1:0]          cfg_dst_w,
    input  logic                cfg_src_inc,
    input  logic                cfg_dst_inc,
    input  logic                cfg_circ,
    input  logic [2:0]          cfg_ie,
    input  logic                grant,
    output logic                rd_req,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic [1:0]          rd_size,
    input  logic                rd_ack,
    input  logic [DMACH_DW-1:0] rd_data,
    input  logic                rd_err,
    output logic                wr_req,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [1:0]          wr_size,
    output logic [DMACH_DW-1:0] wr_data,
    input  logic                wr_ack,
    input  logic                wr_err,
    input  logic                clr_ht,
    input  logic                clr_tc,
    input  logic                clr_te,
    output logic                flag_ht,
    output logic                flag_tc,
    output logic                flag_te,
    output logic                irq,
    output logic                active,
    output logic [CNT_W:0]      remain
);

    seq_st_e             st_q;
    logic                en_q;
    logic [1:0]          sw_q, dw_q;
    logic                si_q, di_q, circ_q;
    logic [DMACH_DW-1:0] data_q;

    logic       cfg_ok, start, go, bad;
    logic       rd_done, rd_fail, wr_done, wr_fail, item_done;
    logic       last, ht_evt, tc_evt;
    logic [1:0] narrow_w;
    logic [FL_N-1:0] fl_set, fl_clr, fl_vec;

    // Event decode.
    assign start     = ch_en & ~en_q & (st_q == ST_IDLE);
    assign go        = start & cfg_ok;
    assign bad       = start & ~cfg_ok;
    assign rd_done   = ch_en & (st_q == ST_RD) & rd_ack;
    assign rd_fail   = rd_done & rd_err;
    assign wr_done   = ch_en & (st_q == ST_WR) & wr_ack;
    assign wr_fail   = wr_done & wr_err;
    assign item_done = wr_done & ~wr_err;
    assign narrow_w  = (sw_q < dw_q) ? sw_q : dw_q;

    dmach_cfg_chk u_chk (
        .src_lo (cfg_src_addr[1:0]),
        .dst_lo (cfg_dst_addr[1:0]),
        .src_w  (cfg_src_w),
        .dst_w  (cfg_dst_w),
        .cfg_ok (cfg_ok)
    );

    // Per-side address generators.
    logic [ADDR_W-1:0] side_ld [2];
    logic [ADDR_W-1:0] side_cur[2];
    logic              side_inc[2];
    logic [1:0]        side_w  [2];

    assign side_ld[0]  = cfg_src_addr;
    assign side_ld[1]  = cfg_dst_addr;
    assign side_inc[0] = si_q;
    assign side_inc[1] = di_q;
    assign side_w[0]   = sw_q;
    assign side_w[1]   = dw_q;

    for (genvar g = 0; g < 2; g++) begin : g_addr
        dmach_addr_gen #(.ADDR_W(ADDR_W)) u_gen (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld      (go),
            .ld_addr (side_ld[g]),
            .adv     (item_done),
            .inc     (side_inc[g]),
            .width   (side_w[g]),
            .rewind  (last & circ_q),
            .cur     (side_cur[g])
        );
    end

    dmach_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (go),
        .ld_cnt (cfg_count),
        .circ   (circ_q),
        .step   (item_done),
        .remain (remain),
        .last   (last),
        .ht_evt (ht_evt),
        .tc_evt (tc_evt)
    );

    assign fl_set[FL_HT] = ht_evt;
    assign fl_set[FL_TC] = tc_evt;
    assign fl_set[FL_TE] = bad | rd_fail | wr_fail;
    assign fl_clr[FL_HT] = clr_ht;
    assign fl_clr[FL_TC] = clr_tc;
    assign fl_clr[FL_TE] = clr_te;

    dmach_flags #(.NF(FL_N)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fl_set),
        .clr   (fl_clr),
        .ie    (cfg_ie),
        .flags (fl_vec),
        .irq   (irq)
    );

    // Enable edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= ch_en;
        end
    end

    // Capture widths, increments and mode on a good start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q   <= XW_BYTE;
            dw_q   <= XW_BYTE;
            si_q   <= 1'b0;
            di_q   <= 1'b0;
            circ_q <= 1'b0;
        end else if (go) begin
            sw_q   <= cfg_src_w;
            dw_q   <= cfg_dst_w;
            si_q   <= cfg_src_inc;
            di_q   <= cfg_dst_inc;
            circ_q <= cfg_circ;
        end
    end

    // Hold the converted item between its read and its write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_done & ~rd_err) begin
            data_q <= rd_data & xw_mask(narrow_w);
        end
    end

    // Channel sequencing: idle, wait for grant, read, write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else if (!ch_en) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: if (go) st_q <= ST_WAIT;
                ST_WAIT: if (grant) st_q <= ST_RD;
                ST_RD: begin
                    if (rd_ack) st_q <= rd_err ? ST_IDLE : ST_WR;
                end
                ST_WR: begin
                    if (wr_ack) begin
                        if (wr_err || (last && !circ_q)) st_q <= ST_IDLE;
                        else                             st_q <= ST_WAIT;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign active  = (st_q != ST_IDLE);
    assign rd_req  = (st_q == ST_RD);
    assign wr_req  = (st_q == ST_WR);
    assign rd_addr = side_cur[0];
    assign wr_addr = side_cur[1];
    assign rd_size = sw_q;
    assign wr_size = dw_q;
    assign wr_data = data_q;
    assign flag_ht = fl_vec[FL_HT];
    assign flag_tc = fl_vec[FL_TC];
    assign flag_te = fl_vec[FL_TE];

endmodule

// File: rtl/dmach_seq_chk.sv
// Protocol checker for the channel sequencer, bound to every instance.
module dmach_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ch_en,
    input logic              rd_req,
    input logic              rd_ack,
    input logic              rd_err,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_req,
    input logic              wr_ack,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W:0]    remain,
    input logic              flag_tc,
    input logic              active
);

    localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};
    localparam logic [CNT_W:0] ONE  = {{CNT_W{1'b0}}, 1'b1};

    // R2
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack && ch_en) |=> (rd_req && $stable(rd_addr)));

    // R2
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack && ch_en) |=> (wr_req && $stable(wr_addr)));

    // R1
    rem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remain <= FULL);

    // R5
    tc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_tc) |-> ($past(remain) == ONE));

    // R12
    off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |=> (!active && !rd_req && !wr_req));

    // R9
    rd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && rd_err) |=> !active);

endmodule

bind dmach_seq dmach_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ch_en   (ch_en),
    .rd_req  (rd_req),
    .rd_ack  (rd_ack),
    .rd_err  (rd_err),
    .rd_addr (rd_addr),
    .wr_req  (wr_req),
    .wr_ack  (wr_ack),
    .wr_addr (wr_addr),
    .remain  (remain),
    .flag_tc (flag_tc),
    .active  (active)
);

// File: tb/dmach_seq_test.sv
// Bench: behavioural reference model stepped on every rising edge and
// compared with the design on every falling edge.
module dmach_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ch_en = 1'b0;
    logic [31:0] cfg_src_addr = '0, cfg_dst_addr = '0;
    logic [15:0] cfg_count = '0;
    logic [1:0]  cfg_src_w = '0, cfg_dst_w = '0;
    logic        cfg_src_inc = 1'b0, cfg_dst_inc = 1'b0, cfg_circ = 1'b0;
    logic [2:0]  cfg_ie = '0;
    logic        grant = 1'b0;
    logic        rd_req, wr_req;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic [1:0]  rd_size, wr_size;
    logic        rd_ack = 1'b0, rd_err = 1'b0, wr_ack = 1'b0, wr_err = 1'b0;
    logic [31:0] rd_data = '0;
    logic        clr_ht = 1'b0, clr_tc = 1'b0, clr_te = 1'b0;
    logic        flag_ht, flag_tc, flag_te, irq, active;
    logic [16:0] remain;

    always #4 clk = ~clk;   // 125 MHz

    dmach_seq uut (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_count(cfg_count), .cfg_src_w(cfg_src_w), .cfg_dst_w(cfg_dst_w),
        .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
        .cfg_circ(cfg_circ), .cfg_ie(cfg_ie), .grant(grant),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
        .rd_ack(rd_ack), .rd_data(rd_data), .rd_err(rd_err),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_data(wr_data), .wr_ack(wr_ack), .wr_err(wr_err),
        .clr_ht(clr_ht), .clr_tc(clr_tc), .clr_te(clr_te),
        .flag_ht(flag_ht), .flag_tc(flag_tc), .flag_te(flag_te),
        .irq(irq), .active(active), .remain(remain)
    );

    int  n_vec = 0, n_bad = 0;
    bit  cmp_on = 0, finished = 0;
    int  inj_rd_req = 0, inj_rd_done = 0, inj_wr_req = 0, inj_wr_done = 0;

    // ---------------- reference model ----------------
    int          m_mode = 0;      // 0 off, 1 waiting, 2 reading, 3 writing
    int          m_rem = 0, m_tot = 0, m_sw = 0, m_dw = 0;
    bit          m_si, m_di, m_circ, m_enq;
    bit [31:0]   m_src, m_dst, m_psrc, m_pdst, m_data;
    bit          m_ht, m_tc, m_te;

    function automatic int nbytes(int w);
        return (w == 0) ? 1 : (w == 1) ? 2 : 4;
    endfunction

    function automatic bit [31:0] wmask(int w);
        return (w == 0) ? 32'hFF : (w == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic bit aligned(bit [31:0] a, int w);
        return (a % nbytes(w)) == 0;
    endfunction

    always @(posedge clk) begin
        bit s_ht, s_tc, s_te, start;
        s_ht = 0; s_tc = 0; s_te = 0;
        if (!rst_n) begin
            m_mode = 0; m_rem = 0; m_tot = 0; m_sw = 0; m_dw = 0;
            m_si = 0; m_di = 0; m_circ = 0; m_enq = 0;
            m_src = 0; m_dst = 0; m_psrc = 0; m_pdst = 0; m_data = 0;
            m_ht = 0; m_tc = 0; m_te = 0;
        end else begin
            start = ch_en && !m_enq && m_mode == 0;
            if (!ch_en) begin
                m_mode = 0;
            end else if (m_mode == 0) begin
                if (start) begin
                    if (cfg_src_w == 3 || cfg_dst_w == 3 ||
                        !aligned(cfg_src_addr, cfg_src_w) ||
                        !aligned(cfg_dst_addr, cfg_dst_w)) begin
                        s_te = 1;
                    end else begin
                        m_tot = (cfg_count == 0) ? 65536 : cfg_count;
                        m_rem = m_tot;
                        m_src = cfg_src_addr; m_psrc = cfg_src_addr;
                        m_dst = cfg_dst_addr; m_pdst = cfg_dst_addr;
                        m_sw = cfg_src_w; m_dw = cfg_dst_w;
                        m_si = cfg_src_inc; m_di = cfg_dst_inc;
                        m_circ = cfg_circ;
                        m_mode = 1;
                    end
                end
            end else if (m_mode == 1) begin
                if (grant) m_mode = 2;
            end else if (m_mode == 2) begin
                if (rd_ack) begin
                    if (rd_err) begin
                        s_te = 1; m_mode = 0;
                    end else begin
                        m_data = rd_data & wmask((m_sw < m_dw) ? m_sw : m_dw);
                        m_mode = 3;
                    end
                end
            end else begin
                if (wr_ack) begin
                    if (wr_err) begin
                        s_te = 1; m_mode = 0;
                    end else begin
                        if (m_si) m_src = m_src + nbytes(m_sw);
                        if (m_di) m_dst = m_dst + nbytes(m_dw);
                        if (m_rem - 1 == m_tot / 2) s_ht = 1;
                        if (m_rem == 1) begin
                            s_tc = 1;
                            if (m_circ) begin
                                m_rem = m_tot; m_src = m_psrc; m_dst = m_pdst;
                                m_mode = 1;
                            end else begin
                                m_rem = 0; m_mode = 0;
                            end
                        end else begin
                            m_rem = m_rem - 1; m_mode = 1;
                        end
                    end
                end
            end
            m_ht = s_ht | (m_ht & !clr_ht);
            m_tc = s_tc | (m_tc & !clr_tc);
            m_te = s_te | (m_te & !clr_te);
            m_enq = ch_en;
        end
    end

    // ---------------- comparison ----------------
    task automatic cmp(input string tag, input string nm,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            cmp("R1", "active", 64'(active), 64'(m_mode != 0));
            cmp("R5", "remain", 64'(remain), 64'(m_rem));
            cmp("R2", "rd_req", 64'(rd_req), 64'(m_mode == 2));
            cmp("R2", "wr_req", 64'(wr_req), 64'(m_mode == 3));
            if (rd_req === 1'b1 && m_mode == 2) begin
                cmp("R3", "rd_addr", 64'(rd_addr), 64'(m_src));
                cmp("R2", "rd_size", 64'(rd_size), 64'(m_sw));
            end
            if (wr_req === 1'b1 && m_mode == 3) begin
                cmp("R3", "wr_addr", 64'(wr_addr), 64'(m_dst));
                cmp("R2", "wr_size", 64'(wr_size), 64'(m_dw));
                cmp("R4", "wr_data", 64'(wr_data), 64'(m_data));
            end
            cmp("R7", "flag_ht", 64'(flag_ht), 64'(m_ht));
            cmp("R5", "flag_tc", 64'(flag_tc), 64'(m_tc));
            cmp("R8|R9", "flag_te", 64'(flag_te), 64'(m_te));
            cmp("R11", "irq", 64'(irq),
                64'((m_ht & cfg_ie[0]) | (m_tc & cfg_ie[1]) | (m_te & cfg_ie[2])));
        end
    end

    // ---------------- bus and arbiter responder ----------------
    bit [31:0] lf = 32'h1BAD_F00D;
    always @(negedge clk) begin
        lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
        grant  = (lf[3:2] != 2'b00);
        rd_ack = 0; rd_err = 0; wr_ack = 0; wr_err = 0;
        if (rst_n && rd_req === 1'b1 && lf[0]) begin
            rd_ack  = 1;
            rd_data = lf ^ 32'hA5C3_96E1;
            if (inj_rd_req != inj_rd_done) begin
                rd_err = 1; inj_rd_done++;
            end
        end
        if (rst_n && wr_req === 1'b1 && lf[1]) begin
            wr_ack = 1;
            if (inj_wr_req != inj_wr_done) begin
                wr_err = 1; inj_wr_done++;
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic run(input logic [31:0] s, input logic [31:0] d, input int cnt,
                       input int sw, input int dw, input bit si, input bit di,
                       input bit ci, input logic [2:0] ie, input int max_cyc);
        @(negedge clk);
        cfg_src_addr = s; cfg_dst_addr = d; cfg_count = 16'(cnt);
        cfg_src_w = 2'(sw); cfg_dst_w = 2'(dw);
        cfg_src_inc = si; cfg_dst_inc = di; cfg_circ = ci; cfg_ie = ie;
        ch_en = 1;
        for (int i = 0; i < max_cyc; i++) begin
            @(negedge clk);
            if (i > 1 && !active) break;
        end
        ch_en = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear(input logic [2:0] m);
        @(negedge clk);
        {clr_te, clr_tc, clr_ht} = m;
        @(negedge clk);
        {clr_te, clr_tc, clr_ht} = 3'b000;
        @(negedge clk);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        cmp_on = 1;                      // R1 reset state: idle, zero count, no flags
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1;
        repeat (3) @(negedge clk);
        // word to word, both incrementing, even count
        run(32'h1000, 32'h2000, 4, 2, 2, 1, 1, 0, 3'b111, 300);
        clear(3'b001);                   // R10: only half flag clears
        repeat (3) @(negedge clk);
        clear(3'b110);
        // byte to word, destination fixed, odd count (R7 rounding)
        run(32'h3001, 32'h4000, 5, 0, 2, 1, 0, 0, 3'b010, 300);
        clear(3'b111);
        // word to half-word, truncation (R4)
        run(32'h5000, 32'h6002, 3, 2, 1, 1, 1, 0, 3'b001, 300);
        clear(3'b111);
        // R6 circular over several wraps, then R12 drop of enable
        run(32'h7000, 32'h8000, 3, 1, 1, 1, 1, 1, 3'b111, 90);
        clear(3'b111);
        // R8 misaligned half-word source
        run(32'h9001, 32'hA000, 2, 1, 0, 1, 1, 0, 3'b100, 20);
        clear(3'b100);
        // R8 illegal width code
        run(32'hB000, 32'hC000, 2, 3, 0, 1, 1, 0, 3'b100, 20);
        clear(3'b100);
        // R9 read error part-way
        inj_rd_req++;
        run(32'hD000, 32'hE000, 4, 2, 0, 1, 1, 0, 3'b111, 300);
        clear(3'b111);
        // R9 write error
        inj_wr_req++;
        run(32'hD100, 32'hE100, 4, 0, 1, 1, 1, 0, 3'b100, 300);
        clear(3'b111);
        // R1 count of zero means 65536, cut short by R12
        run(32'hF000, 32'hF800, 0, 1, 2, 1, 1, 0, 3'b111, 40);
        clear(3'b111);
        // single item: half and complete together (R7)
        run(32'h0010, 32'h0020, 1, 0, 0, 0, 0, 0, 3'b011, 100);
        clear(3'b111);
        repeat (4) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule